// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block takes a processor core into a low-power sleep state and brings it back out. A single-cycle request from the instruction decoder, issued when the sleep instruction executes, removes the core's clock enable. The peripheral clock enable and the external clock output stay on throughout. This lets timers, interfaces and interrupt sources keep running while the core is frozen with its registers intact. A two-bit status output shows external logic whether the chip is running or asleep.

If the peripheral units that must finish before sleep are still busy, the request is held. Sleep is entered only once they report idle. Sleep ends on an interrupt from any source, and in sleep the global interrupt-block bit does not mask wake-up. On an interrupt wake the block raises a one-cycle wake pulse and latches an event code that identifies the waking source for the exception logic. Any of the four reset causes instead returns the block to its reset state and clears the code.

Top module: `sleep_power_ctl`

## Requirements
- R1: After reset the block is in the run state: `cpu_clk_en`=1, `pwr_stat`=2'b00, `wake_pulse`=0, `evt_code`=0.
- R2: With `periph_busy` low and no unmasked interrupt, a `sleep_req` pulse puts the block to sleep at the next clock edge: `cpu_clk_en`=0 and `pwr_stat`=2'b10 (bit 1 high, bit 0 low).
- R3: `per_clk_en` and `clkout_en` are 1 in every state, asleep or awake.
- R4: A sleep request that arrives while `periph_busy` is high is held pending, with `cpu_clk_en`=1 and `pwr_stat`=2'b00. Sleep is entered at the edge where `periph_busy` is sampled low.
- R5: In sleep, any active line on `nmi_req`, `ext_irq` or `onchip_irq` returns the block to run at the next edge. `wake_pulse` is 1 for exactly that one cycle.
- R6: Wake-up from sleep happens regardless of the value of `int_block`.
- R7: On an interrupt wake `evt_code` takes the waking source's code: NMI = 8'h10, `ext_irq[i]` = 8'h20+i, `onchip_irq[j]` = 8'h40+j. The priority is NMI over external lines over on-chip lines, and the lower index wins within a group. The code holds until the next wake or reset, and interrupts taken while running do not change it.
- R8: Any bit of `rst_cause` (power-on pin, watchdog power-on, debug reset, manual reset), or `rst_n` low, returns the block to the R1 state at the next edge, with no wake pulse.
- R9: In run or while a request is pending, an unmasked interrupt (NMI always, and other lines only when `int_block`=0) cancels the sleep request and the block stays in run. Masked lines do not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle request from the executed sleep instruction |
| periph_busy | input | 1 | Units that must finish before sleep are active |
| int_block | input | 1 | Global interrupt-block bit of the status register |
| nmi_req | input | 1 | Non-maskable interrupt |
| ext_irq | input | 8 | External interrupt request lines |
| onchip_irq | input | 16 | On-chip peripheral interrupt lines |
| rst_cause | input | 4 | Reset causes: power-on pin, watchdog, debug, manual |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clkout_en | output | 1 | External clock output enable |
| pwr_stat | output | 2 | Power state: 00 run, 10 sleep |
| wake_pulse | output | 1 | One-cycle interrupt-wake indication |
| evt_code | output | 8 | Latched code of the waking interrupt source |

## Verification
Some properties are checked on every cycle. Sleep status always coincides with the core clock being off. Sleep is never entered while the busy input was high. The wake pulse lasts one cycle and follows a sleeping cycle. An interrupt in sleep always wakes the block by the next edge. The event code moves only on a wake or reset, and a reset cause always lands the block in its clean run state. The bench scenarios cover what a cycle property cannot show: the actual code values and source priority, masked versus unmasked interrupts colliding with a request, cancellation of a pending request, and the clock enables that stay on.

// File: rtl/slp_pkg.sv
// Shared types and constants of the sleep power controller.
// Assumes an 8-bit event code wide enough for all source offsets.
package slp_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PEND  = 2'd1,
        ST_SLEEP = 2'd2
    } slp_state_e;

    localparam logic [CODE_W-1:0] CODE_NMI  = 8'h10;
    localparam logic [CODE_W-1:0] BASE_EXT  = 8'h20;
    localparam logic [CODE_W-1:0] BASE_ONC  = 8'h40;

    localparam logic [1:0] STAT_RUN   = 2'b00;
    localparam logic [1:0] STAT_SLEEP = 2'b10;
endpackage

// File: rtl/slp_wake_src.sv
// Wake source encoder: flags any pending interrupt and forms the event
// code of the highest-priority one (NMI, then external, then on-chip,
// lowest index first). Assumes inputs are already synchronous.
module slp_wake_src
    import slp_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int NUM_ONC = 16
) (
    input  logic               nmi,
    input  logic [NUM_EXT-1:0] ext,
    input  logic [NUM_ONC-1:0] onc,
    output logic               any_irq,
    output logic               any_maskable,
    output logic [CODE_W-1:0]  code
);
    // Request summary flags for the state machine.
    always_comb begin
        any_maskable = (|ext) | (|onc);
        any_irq      = nmi | any_maskable;
    end

    // Priority encode: later assignments override earlier ones.
    always_comb begin
        code = '0;
        for (int j = NUM_ONC - 1; j >= 0; j--) begin
            if (onc[j]) code = BASE_ONC + CODE_W'(j);
        end
        for (int i = NUM_EXT - 1; i >= 0; i--) begin
            if (ext[i]) code = BASE_EXT + CODE_W'(i);
        end
        if (nmi) code = CODE_NMI;
    end
endmodule

// File: rtl/slp_fsm.sv
// Run / pending / sleep state machine with the wake pulse and event code
// register. Assumes sleep_req is a single-cycle pulse and that reset
// causes take precedence over every other input.
module slp_fsm
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_any,
    input  logic              sleep_req,
    input  logic              busy,
    input  logic              intr_run,
    input  logic              intr_sleep,
    input  logic [CODE_W-1:0] code_in,
    output slp_state_e        state,
    output logic              wake_pulse,
    output logic [CODE_W-1:0] evt_code
);
    slp_state_e state_nx;

    // Next-state selection; an unmasked interrupt always keeps the core running.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (sleep_req && !intr_run)
                    state_nx = busy ? ST_PEND : ST_SLEEP;
            end
            ST_PEND: begin
                if (intr_run)   state_nx = ST_RUN;
                else if (!busy) state_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (intr_sleep) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State, wake pulse and event code registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_any) begin
            state      <= ST_RUN;
            wake_pulse <= 1'b0;
            evt_code   <= '0;
        end else begin
            state      <= state_nx;
            wake_pulse <= (state == ST_SLEEP) && intr_sleep;
            if ((state == ST_SLEEP) && intr_sleep)
                evt_code <= code_in;
        end
    end
endmodule

// File: rtl/sleep_power_ctl.sv
// Sleep mode power controller top. Stops the core clock enable in sleep,
// keeps peripheral and external clocks on, drives the status pins and
// reports the waking interrupt. Assumes all inputs are synchronous to clk.
module sleep_power_ctl
    import slp_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int NUM_ONC = 16,
    parameter int NUM_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               periph_busy,
    input  logic               int_block,
    input  logic               nmi_req,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_ONC-1:0] onchip_irq,
    input  logic [NUM_RST-1:0] rst_cause,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               clkout_en,
    output logic [1:0]         pwr_stat,
    output logic               wake_pulse,
    output logic [CODE_W-1:0]  evt_code
);
    logic       any_irq, any_maskable, intr_run;
    logic [CODE_W-1:0] src_code;
    slp_state_e state;

    slp_wake_src #(.NUM_EXT(NUM_EXT), .NUM_ONC(NUM_ONC)) u_src (
        .nmi          (nmi_req),
        .ext          (ext_irq),
        .onc          (onchip_irq),
        .any_irq      (any_irq),
        .any_maskable (any_maskable),
        .code         (src_code)
    );

    // Interrupt that may preempt a sleep request while running.
    always_comb intr_run = nmi_req | (any_maskable & ~int_block);

    slp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_any    (|rst_cause),
        .sleep_req  (sleep_req),
        .busy       (periph_busy),
        .intr_run   (intr_run),
        .intr_sleep (any_irq),
        .code_in    (src_code),
        .state      (state),
        .wake_pulse (wake_pulse),
        .evt_code   (evt_code)
    );

    // Output decode from the current power state.
    always_comb begin
        cpu_clk_en = (state != ST_SLEEP);
        per_clk_en = 1'b1;
        clkout_en  = 1'b1;
        pwr_stat   = (state == ST_SLEEP) ? STAT_SLEEP : STAT_RUN;
    end

    assert_stat_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_stat == STAT_SLEEP) == !cpu_clk_en);

    assert_no_busy_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && $past(cpu_clk_en)) |-> !$past(periph_busy));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_pulse_after_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (cpu_clk_en && !$past(cpu_clk_en)));

    assert_sleep_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && any_irq && rst_cause == '0) |=> (cpu_clk_en && wake_pulse));

    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_pulse && $past(rst_n) && $past(rst_cause) == '0) |-> $stable(evt_code));

    assert_reset_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_cause) |=> (cpu_clk_en && !wake_pulse && evt_code == '0));

    assert_nmi_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && nmi_req && rst_cause == '0) |=> cpu_clk_en);
endmodule

// File: tb/test_sleep_power_ctl.sv
module test_sleep_power_ctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sleep_req, periph_busy, int_block, nmi_req;
    logic [7:0]  ext_irq;
    logic [15:0] onchip_irq;
    logic [3:0]  rst_cause;
    logic        cpu_clk_en, per_clk_en, clkout_en, wake_pulse;
    logic [1:0]  pwr_stat;
    logic [7:0]  evt_code;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_power_ctl i_sleep_power_ctl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .periph_busy(periph_busy),
        .int_block(int_block), .nmi_req(nmi_req), .ext_irq(ext_irq),
        .onchip_irq(onchip_irq), .rst_cause(rst_cause), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .clkout_en(clkout_en), .pwr_stat(pwr_stat),
        .wake_pulse(wake_pulse), .evt_code(evt_code)
    );

    typedef struct packed {
        logic       req;
        logic       busy;
        logic       nmi;
        logic [7:0] ext;
        logic [15:0] onc;
        logic       blk;
        logic [3:0] rsrc;
        logic       e_cpu;
        logic [1:0] e_st;
        logic       e_pulse;
        logic [7:0] e_code;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h00}, // idle run
        '{1'b1,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b0,2'b10,1'b0,8'h00}, // R2 enter
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b0,2'b10,1'b0,8'h00}, // stay asleep
        '{1'b0,1'b0,1'b0,8'h08,16'h0000,1'b1,4'h0, 1'b1,2'b00,1'b1,8'h23}, // R6 wake with block bit
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h23}, // R5 pulse ends
        '{1'b1,1'b1,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h23}, // R4 pending
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h23}, // R4 still busy
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b0,2'b10,1'b0,8'h23}, // R4 enter after idle
        '{1'b0,1'b0,1'b0,8'h40,16'h0020,1'b0,4'h0, 1'b1,2'b00,1'b1,8'h26}, // R7 ext over on-chip
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h26},
        '{1'b1,1'b0,1'b1,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h26}, // R9 NMI wins
        '{1'b1,1'b0,1'b0,8'h02,16'h0000,1'b1,4'h0, 1'b0,2'b10,1'b0,8'h26}, // R9 masked line
        '{1'b0,1'b0,1'b1,8'h01,16'h0001,1'b0,4'h0, 1'b1,2'b00,1'b1,8'h10}, // R7 NMI first
        '{1'b1,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b0,2'b10,1'b0,8'h10},
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h4, 1'b1,2'b00,1'b0,8'h00}, // R8 reset cause
        '{1'b0,1'b0,1'b0,8'h00,16'h8000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h00}, // R7 run irq no code
        '{1'b1,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b0,2'b10,1'b0,8'h00},
        '{1'b0,1'b0,1'b0,8'h00,16'h8000,1'b0,4'h0, 1'b1,2'b00,1'b1,8'h4F}, // R7 top on-chip
        '{1'b1,1'b1,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h4F}, // R4 pending
        '{1'b0,1'b1,1'b0,8'h04,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h4F}, // R9 cancel pending
        '{1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b1,2'b00,1'b0,8'h4F}, // R9 stays run
        '{1'b1,1'b0,1'b0,8'h00,16'h0000,1'b0,4'h0, 1'b0,2'b10,1'b0,8'h4F}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sleep_req = 1'b0; periph_busy = 1'b0; int_block = 1'b0; nmi_req = 1'b0;
        ext_irq = '0; onchip_irq = '0; rst_cause = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cpu_clk_en", {7'd0, cpu_clk_en}, 8'h01);
        chk("R1 pwr_stat", {6'd0, pwr_stat}, 8'h00);
        chk("R1 wake_pulse", {7'd0, wake_pulse}, 8'h00);
        chk("R1 evt_code", evt_code, 8'h00);

        for (int k = 0; k < NV; k++) begin
            sleep_req = VECS[k].req; periph_busy = VECS[k].busy; nmi_req = VECS[k].nmi;
            ext_irq = VECS[k].ext; onchip_irq = VECS[k].onc; int_block = VECS[k].blk;
            rst_cause = VECS[k].rsrc;
            @(negedge clk);
            chk($sformatf("R2 cpu_clk_en row %0d", k), {7'd0, cpu_clk_en}, {7'd0, VECS[k].e_cpu});
            chk($sformatf("R2 pwr_stat row %0d", k), {6'd0, pwr_stat}, {6'd0, VECS[k].e_st});
            chk($sformatf("R5 wake_pulse row %0d", k), {7'd0, wake_pulse}, {7'd0, VECS[k].e_pulse});
            chk($sformatf("R7 evt_code row %0d", k), evt_code, VECS[k].e_code);
            chk($sformatf("R3 clocks row %0d", k), {6'd0, per_clk_en, clkout_en}, 8'h03);
        end

        // R8 rst_n while asleep (block ended the table asleep)
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 rst_n cpu_clk_en", {7'd0, cpu_clk_en}, 8'h01);
        chk("R8 rst_n evt_code", evt_code, 8'h00);
        chk("R8 rst_n pwr_stat", {6'd0, pwr_stat}, 8'h00);
        rst_n = 1'b1;

        // R6 wake by NMI with block bit set, then R5 pulse drops
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; int_block = 1'b1; nmi_req = 1'b1;
        @(negedge clk);
        chk("R6 nmi wake pulse", {7'd0, wake_pulse}, 8'h01);
        chk("R7 nmi code", evt_code, 8'h10);
        idle_inputs();
        @(negedge clk);
        chk("R5 pulse cleared", {7'd0, wake_pulse}, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule